// File: doc/BRIEF.md
# Split-Region Descriptor Slot Allocator

This block hands out indices into a fixed pool of descriptor slots. The pool is split into two equal halves. Receive traffic draws from the lower half and transmit traffic draws from the upper half. A client asks for a contiguous run of slots of a given length in one half. The block answers with the lowest start index of a free run that fits. It also returns the byte offset of that slot, which is the index times an aligned descriptor size. The block then marks the run as used.

A free request gives a start index and a length, and the block clears those slots. A counter tracks how many allocations are outstanding. A level output says whether any transmit slot is still free, so a transmit path can hold back before it asks.

Operations are serialised by a request/ready/done handshake. The search steps through one candidate start per cycle, so an allocation takes between 2 and HALF+1 cycles from acceptance to done. A free takes 2 cycles. Only index management is built here; the descriptor memory itself lives elsewhere.

Top module: `slot_alloc`

## Requirements
- R1: A receive allocation (req_dir=0) only ever returns a start index in the range 0 to NUM_SLOTS/2-1, and the whole run stays inside that range.
- R2: A transmit allocation (req_dir=1) only ever returns a start index in the range NUM_SLOTS/2 to NUM_SLOTS-1, and the whole run stays inside that range.
- R3: A successful allocation returns the lowest start index in its half at which req_len consecutive slots are all free, and marks exactly those slots used.
- R4: When no run of the requested length fits in the half, done is raised with done_ok=0 and no slot changes state.
- R5: in_use rises by one on each successful allocation and falls by one on each free (it never goes below zero); a failed allocation leaves it unchanged.
- R6: A free request (req_op=1) clears req_len slots starting at req_index and completes with done_ok=1.
- R7: tx_free_any is 1 exactly when at least one slot in the upper (transmit) half is free.
- R8: On a successful allocation, done_offset equals done_index times DESC_BYTES.
- R9: A request is accepted only on a cycle where req_valid and req_ready are both 1. req_ready is low from the cycle after acceptance until done. done is a one-cycle pulse. A request raised while req_ready is 0 is ignored.
- R10: An allocation with req_len of 0 or greater than MAX_RUN fails (done_ok=0) and changes nothing.
- R11: After reset, req_ready=1, done=0, in_use=0 and tx_free_any=1, with every slot free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can take a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_dir | input | 1 | Allocation half: 0 = receive (lower), 1 = transmit (upper) |
| req_len | input | $clog2(MAX_RUN+1) | Run length in slots |
| req_index | input | $clog2(NUM_SLOTS) | Start index for a free |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | 1 = allocation succeeded or free done |
| done_index | output | $clog2(NUM_SLOTS) | Start index of the run |
| done_offset | output | $clog2(NUM_SLOTS*DESC_BYTES) | Byte offset of the run start |
| in_use | output | $clog2(NUM_SLOTS+1) | Outstanding allocation count |
| tx_free_any | output | 1 | At least one transmit slot is free |

## Verification
The bench builds the block with NUM_SLOTS=16, MAX_RUN=4 and DESC_BYTES=32. With these values each half has eight slots, so the test can fill a half completely with runs of one to four slots. That makes several cases reachable: a failed allocation while a few slots are still free, the transmit-empty flag going low and then coming back after a free, and a fragmented receive half in which first-fit has to skip a short hole. A free request raised during an eight-cycle failing search tests that a request made while the block is busy is ignored. Lengths of 0 and 5 reach both illegal-length bounds.

// File: rtl/slot_alloc_pkg.sv
// Shared types for the slot allocator: request opcode and controller state.
package slot_alloc_pkg;
    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } slot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FREE   = 2'd2
    } slot_state_e;
endpackage

// File: rtl/slot_window_fit.sv
// Combinational test of one candidate run: reports whether len slots starting
// at cand are all free and all lie below lim. Assumes lim <= N_SLOTS and that
// len has already been range-checked against MAX_RUN by the caller.
module slot_window_fit #(
    parameter int N_SLOTS = 16,
    parameter int MAX_RUN = 4,
    localparam int IDX_W = $clog2(N_SLOTS),
    localparam int LEN_W = $clog2(MAX_RUN + 1)
) (
    input  logic [N_SLOTS-1:0] used,
    input  logic [IDX_W-1:0]   cand,
    input  logic [LEN_W-1:0]   len,
    input  logic [IDX_W:0]     lim,
    output logic               fit
);
    logic [MAX_RUN-1:0] busy;

    // One checker per position in the window; a position beyond len is ignored.
    for (genvar k = 0; k < MAX_RUN; k++) begin : g_pos
        logic [IDX_W:0] pos;
        assign pos = {1'b0, cand} + (IDX_W+1)'(k);
        assign busy[k] = (LEN_W'(k) < len) &&
                         ((pos >= lim) || used[pos[IDX_W-1:0]]);
    end

    // A zero-length run never fits.
    assign fit = (len != '0) && (busy == '0);
endmodule

// File: rtl/slot_bitmap.sv
// Slot occupancy register. Sets or clears a run of len slots from start in
// one cycle; runs are clipped at the top of the pool. Assumes set_en and
// clr_en are never high together.
module slot_bitmap #(
    parameter int N_SLOTS = 16,
    parameter int MAX_RUN = 4,
    localparam int IDX_W = $clog2(N_SLOTS),
    localparam int LEN_W = $clog2(MAX_RUN + 1),
    localparam int HALF  = N_SLOTS / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   start,
    input  logic [LEN_W-1:0]   len,
    output logic [N_SLOTS-1:0] used,
    output logic               tx_any_free
);
    logic [N_SLOTS-1:0] run_mask;

    // Decode the run [start, start+len) into a slot mask.
    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            run_mask[i] = (i >= int'(start)) && ((i - int'(start)) < int'(len));
        end
    end

    // Occupancy update: set on allocation, clear on free.
    always_ff @(posedge clk) begin
        if (!rst_n)       used <= '0;
        else if (set_en)  used <= used | run_mask;
        else if (clr_en)  used <= used & ~run_mask;
    end

    // Any free slot in the upper (transmit) half.
    assign tx_any_free = ~&used[N_SLOTS-1:HALF];

    // R3: a run is only claimed when none of its slots is held.
    p_claim_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((used & run_mask) == '0));

    // R9: the controller issues at most one update per cycle.
    p_one_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
endmodule

// File: rtl/slot_alloc.sv
// Split-region slot allocator. Receive runs come from the lower half of the
// pool and transmit runs from the upper half; the search is first-fit, with
// one candidate start per cycle. Assumes NUM_SLOTS is a power of two >= 2
// and MAX_RUN <= NUM_SLOTS/2.
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int MAX_RUN    = 4,
    parameter int DESC_BYTES = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int LEN_W = $clog2(MAX_RUN + 1),
    localparam int CNT_W = $clog2(NUM_SLOTS + 1),
    localparam int OFF_W = $clog2(NUM_SLOTS * DESC_BYTES),
    localparam int HALF  = NUM_SLOTS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_op,
    input  logic             req_dir,
    input  logic [LEN_W-1:0] req_len,
    input  logic [IDX_W-1:0] req_index,
    output logic             done,
    output logic             done_ok,
    output logic [IDX_W-1:0] done_index,
    output logic [OFF_W-1:0] done_offset,
    output logic [CNT_W-1:0] in_use,
    output logic             tx_free_any
);
    slot_state_e          state;
    slot_op_e             op_q;
    logic                 dir_q;
    logic [LEN_W-1:0]     len_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     cand;
    logic [IDX_W-1:0]     last_cand;
    logic [IDX_W:0]       lim;
    logic                 fit_raw;
    logic                 fit;
    logic                 len_ok;
    logic [NUM_SLOTS-1:0] used;
    logic                 set_en;
    logic                 clr_en;
    logic [IDX_W-1:0]     upd_start;
    logic                 accept;

    assign accept    = req_valid && req_ready;
    assign req_ready = (state == ST_IDLE);

    // Window end and last candidate for the chosen half.
    assign lim       = dir_q ? (IDX_W+1)'(NUM_SLOTS) : (IDX_W+1)'(HALF);
    assign last_cand = dir_q ? IDX_W'(NUM_SLOTS - 1) : IDX_W'(HALF - 1);
    assign len_ok    = (len_q != '0) && (int'(len_q) <= MAX_RUN);
    assign fit       = fit_raw && len_ok;

    // Bitmap update strobes from the controller state.
    assign set_en    = (state == ST_SEARCH) && fit;
    assign clr_en    = (state == ST_FREE);
    assign upd_start = (state == ST_FREE) ? idx_q : cand;

    slot_window_fit #(.N_SLOTS(NUM_SLOTS), .MAX_RUN(MAX_RUN)) u_fit (
        .used (used),
        .cand (cand),
        .len  (len_q),
        .lim  (lim),
        .fit  (fit_raw)
    );

    slot_bitmap #(.N_SLOTS(NUM_SLOTS), .MAX_RUN(MAX_RUN)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (set_en),
        .clr_en      (clr_en),
        .start       (upd_start),
        .len         (len_q),
        .used        (used),
        .tx_any_free (tx_free_any)
    );

    // Controller: accept, step the search, complete and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            op_q        <= OP_ALLOC;
            dir_q       <= 1'b0;
            len_q       <= '0;
            idx_q       <= '0;
            cand        <= '0;
            done        <= 1'b0;
            done_ok     <= 1'b0;
            done_index  <= '0;
            done_offset <= '0;
            in_use      <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q  <= slot_op_e'(req_op);
                        dir_q <= req_dir;
                        len_q <= req_len;
                        idx_q <= req_index;
                        cand  <= req_dir ? IDX_W'(HALF) : '0;
                        state <= req_op ? ST_FREE : ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (fit) begin
                        done        <= 1'b1;
                        done_ok     <= 1'b1;
                        done_index  <= cand;
                        done_offset <= OFF_W'(int'(cand) * DESC_BYTES);
                        in_use      <= in_use + CNT_W'(1);
                        state       <= ST_IDLE;
                    end else if (!len_ok || cand == last_cand) begin
                        done    <= 1'b1;
                        done_ok <= 1'b0;
                        state   <= ST_IDLE;
                    end else begin
                        cand <= cand + IDX_W'(1);
                    end
                end
                ST_FREE: begin
                    done        <= 1'b1;
                    done_ok     <= 1'b1;
                    done_index  <= idx_q;
                    done_offset <= OFF_W'(int'(idx_q) * DESC_BYTES);
                    if (in_use != '0) in_use <= in_use - CNT_W'(1);
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: receive results stay in the lower half.
    p_rx_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && op_q == OP_ALLOC && !dir_q) |-> (int'(done_index) < HALF));

    // R2: transmit results stay in the upper half.
    p_tx_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && op_q == OP_ALLOC && dir_q) |-> (int'(done_index) >= HALF));

    // R4: a failed allocation leaves the occupancy untouched.
    p_fail_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> $stable(used));

    // R5: a successful allocation counts up by one.
    p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && op_q == OP_ALLOC) |-> (in_use == $past(in_use) + CNT_W'(1)));

    // R9: completion coincides with the return to idle, as a single pulse.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !$past(done)));
endmodule

// File: tb/slot_alloc_bench.sv
// Directed bench for slot_alloc: one task per scenario, each checking itself.
module slot_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int MR  = 4;
    localparam int DB  = 32;
    localparam int IW  = $clog2(N);
    localparam int LW  = $clog2(MR + 1);
    localparam int CW  = $clog2(N + 1);
    localparam int OW  = $clog2(N * DB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic          req_dir = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [IW-1:0] req_index = '0;
    logic          done;
    logic          done_ok;
    logic [IW-1:0] done_index;
    logic [OW-1:0] done_offset;
    logic [CW-1:0] in_use;
    logic          tx_free_any;

    int errors = 0;
    int checks = 0;
    int exp_use = 0;
    logic          r_ok;
    int            r_idx;
    int            r_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_alloc #(.NUM_SLOTS(N), .MAX_RUN(MR), .DESC_BYTES(DB)) u_slot_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_dir(req_dir), .req_len(req_len), .req_index(req_index),
        .done(done), .done_ok(done_ok), .done_index(done_index),
        .done_offset(done_offset), .in_use(in_use), .tx_free_any(tx_free_any)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Issue one request and wait for its done pulse; results in r_*.
    task automatic issue(input bit op, input bit dir, input int len, input int idx);
        @(negedge clk);
        req_op = op; req_dir = dir; req_len = LW'(len); req_index = IW'(idx);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
        while (!done) @(negedge clk);
        r_ok = done_ok; r_idx = int'(done_index); r_off = int'(done_offset);
    endtask

    task automatic alloc_expect(input bit dir, input int len, input int exp_idx, input string tag);
        issue(1'b0, dir, len, 0);
        if (exp_idx < 0) begin
            check(r_ok == 1'b0, {tag, " fail flag"}, int'(r_ok), 0);
        end else begin
            exp_use++;
            check(r_ok == 1'b1, {tag, " ok flag"}, int'(r_ok), 1);
            check(r_idx == exp_idx, {tag, " index"}, r_idx, exp_idx);
            check(r_off == exp_idx * DB, "R8 offset", r_off, exp_idx * DB);
        end
        check(int'(in_use) == exp_use, "R5 in_use", int'(in_use), exp_use);
    endtask

    task automatic free_run(input int idx, input int len);
        issue(1'b1, 1'b0, len, idx);
        if (exp_use > 0) exp_use--;
        check(r_ok == 1'b1, "R6 free ok", int'(r_ok), 1);
        check(int'(in_use) == exp_use, "R5 in_use after free", int'(in_use), exp_use);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
        check(done == 1'b0, "R11 done", int'(done), 0);
        check(in_use == '0, "R11 in_use", int'(in_use), 0);
        check(tx_free_any == 1'b1, "R11 tx_free_any", int'(tx_free_any), 1);
    endtask

    task automatic t_basic();
        alloc_expect(1'b0, 1, 0, "R1 rx first");
        alloc_expect(1'b0, 3, 1, "R1 rx run");
        alloc_expect(1'b1, 2, 8, "R2 tx first");
    endtask

    task automatic t_first_fit();
        free_run(0, 1);                       // R6: hole at slot 0
        alloc_expect(1'b0, 2, 4, "R3 skip short hole");
        alloc_expect(1'b0, 1, 0, "R3 reuse freed hole");
    endtask

    task automatic t_rx_full();
        alloc_expect(1'b0, 3, -1, "R4 rx no fit");
        alloc_expect(1'b0, 2, 6, "R4 slots unchanged after fail");
        alloc_expect(1'b0, 1, -1, "R4 rx full");
    endtask

    task automatic t_tx_flag();
        alloc_expect(1'b1, 4, 10, "R2 tx run4");
        alloc_expect(1'b1, 2, 14, "R2 tx top");
        check(tx_free_any == 1'b0, "R7 tx full", int'(tx_free_any), 0);
        alloc_expect(1'b1, 1, -1, "R4 tx full");
    endtask

    // R9: a free raised during a busy search must be ignored.
    task automatic t_ignored();
        @(negedge clk);
        req_op = 1'b0; req_dir = 1'b1; req_len = LW'(1); req_valid = 1'b1;
        @(negedge clk);
        req_op = 1'b1; req_index = IW'(8); req_len = LW'(2);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(done_ok == 1'b0, "R9 search result", int'(done_ok), 0);
        @(negedge clk);
        check(tx_free_any == 1'b0, "R9 busy request ignored", int'(tx_free_any), 0);
        check(int'(in_use) == exp_use, "R9 in_use unchanged", int'(in_use), exp_use);
    endtask

    task automatic t_tx_refill();
        free_run(14, 1);
        check(tx_free_any == 1'b1, "R7 tx slot back", int'(tx_free_any), 1);
        alloc_expect(1'b1, 1, 14, "R3 tx refill");
        check(tx_free_any == 1'b0, "R7 tx full again", int'(tx_free_any), 0);
    endtask

    task automatic t_bad_len();
        alloc_expect(1'b1, 0, -1, "R10 len zero");
        free_run(8, 2);
        alloc_expect(1'b1, 5, -1, "R10 len above max");
        alloc_expect(1'b1, 2, 8, "R10 slots intact after bad len");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_first_fit();
        t_rx_full();
        t_tx_flag();
        t_ignored();
        t_tx_refill();
        t_bad_len();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule